// File: doc/BRIEF.md
# Floating-Point Coprocessor Instruction Field Decoder

This block sits at the front of a floating-point unit's issue path. It takes one 32-bit coprocessor instruction word per cycle. It decides whether the word targets the floating-point coprocessor, sorts it into one of four classes, and pulls out the precision, the arithmetic opcode, the extension sub-opcode and three 5-bit register indices.

Several of the register indices are built from bit fields that are not next to each other. How a field is read depends on the precision and, for the extension opcode, on the sub-opcode. In some cases one operand of a double-precision operation is really a single-width or integer value. Every reserved or illegal bit pattern raises an undefined flag, which the core turns into an undefined-instruction trap.

The decode logic is combinational. All outputs are captured in one register stage, and a valid strobe follows the input strobe by exactly one cycle.

Top module: `fp_cop_decoder`

## Requirements
- R1: The word is accepted only when bits 11:8 hold 10 or 11. Any other value sets the undefined flag. `dbl_o` is 1 exactly when bits 11:8 hold 11.
- R2: The class comes from bits 27:24 and bit 4, encoded as 0 = register transfer, 1 = data processing, 2 = load/store, 3 = two-register transfer. Value 0xE with bit 4 = 1 gives class 0. Value 0xE with bit 4 = 0 gives class 1. Value 0xC or 0xD gives class 2 or 3. Any other value gives class 0, sets the undefined flag and drives `rd_o`, `rn_o`, `rm_o` and `opcode_o` to zero.
- R3: Register transfer:
  - If any of bits 0–3, 5 or 6 is set, the word is undefined.
  - `rd_o` = {0, bits 15:12} and `rm_o` = 0.
  - In single precision, `rn_o` = {bits 19:16, bit 7}.
  - In double precision, `rn_o` = {0, bits 19:16}, and bit 7 set makes the word undefined.
- R4: In data processing, `opcode_o` = {bit 23, bit 21, bit 20, bit 6}. Only opcodes 0–8 and 15 are defined. In every other class, `opcode_o` is 0.
- R5: `ext_o` always carries {bits 19:16, bit 7}. When the opcode is 15, only the sub-opcodes 0–3, 8–11, 15–17 and 24–27 are defined.
- R6: Single-precision data processing:
  - `rd_o` = {bits 15:12, bit 22}, `rn_o` = {bits 19:16, bit 7} and `rm_o` = {bits 3:0, bit 5}.
  - Exception: for opcode 15 with sub-opcode 15 (widening conversion), `rd_o` = {0, bits 15:12}, and bit 22 set makes the word undefined.
- R7: Double-precision data processing:
  - A double-width index is {0, 4-bit field}: `rd_o` from bits 15:12, `rn_o` from bits 19:16, `rm_o` from bits 3:0.
  - Bit 22 set on a double destination is undefined, and so is bit 5 set on a double source.
  - For opcodes other than 15, bit 7 set is undefined. For opcode 15, `rn_o` is the sub-opcode.
- R8: Double-precision data processing with opcode 15:
  - Sub-opcode 15 or any sub-opcode above 17 gives a single-width destination `rd_o` = {bits 15:12, bit 22}.
  - Sub-opcodes 16 and 17 give a single-width source `rm_o` = {bits 3:0, bit 5}.
- R9: Two-register transfer:
  - Class 3 is chosen only when double precision is selected and bit 22 is set. Otherwise bits 27:24 of 0xC/0xD give class 2.
  - Class 3: `rn_o` = {0, bits 19:16}, `rd_o` = {0, bits 15:12}, `rm_o` = {0, bits 3:0}, and bit 5 set is undefined.
  - Class 2: `rn_o` = {0, bits 19:16}, `rm_o` = 0, and `rd_o` is {0, bits 15:12} in double precision or {bits 15:12, bit 22} in single precision.
- R10: Outputs are updated on the rising clock edge after a cycle with `valid_i` = 1. `valid_o` equals `valid_i` of the previous cycle. Outputs hold their values while `valid_i` = 0.
- R11: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present |
| instr_i | input | 32 | Instruction word |
| valid_o | output | 1 | Decoded outputs refreshed this cycle |
| class_o | output | 2 | Instruction class code |
| dbl_o | output | 1 | Double precision selected |
| opcode_o | output | 4 | Data-processing opcode |
| ext_o | output | 5 | Extension sub-opcode field |
| rd_o | output | 5 | Destination register index |
| rn_o | output | 5 | First source register index |
| rm_o | output | 5 | Second source register index |
| undef_o | output | 1 | Undefined encoding |

## Verification
The bench sweeps every combination of the opcode, sub-opcode, precision and guard bits in the data-processing class, and fills the plain register fields with pseudo-random values. This exposes a decoder that builds a single-width index in the double-precision mixed-width cases, or the reverse: its `rd_o` or `rm_o` would move the low bit to the wrong end or drop it. The sweep also checks that a reserved bit (7, 22 or 5) raises the undefined flag only where the operand really is double-width, so a decoder that tests bit 22 for a single-width destination would trap legal conversions. Separate sweeps cover:
- every value of bits 27:24 against every coprocessor number, which catches a class error or a missed reject;
- all low bits of the register transfer against the reserved mask;
- the two-register selection, which must not fire in single precision.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned FLD_W   = IDX_W - 1;

  localparam logic [3:0] CP_SGL = 4'hA;
  localparam logic [3:0] CP_DBL = 4'hB;
  localparam logic [OP_W-1:0] OP_EXT = 4'd15;

  typedef enum logic [1:0] {
    CLS_RT  = 2'd0,
    CLS_DP  = 2'd1,
    CLS_LS  = 2'd2,
    CLS_TWO = 2'd3
  } cls_e;

  typedef struct packed {
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
    logic             undef;
  } idx_t;

  typedef struct packed {
    cls_e             cls;
    logic             dbl;
    logic [OP_W-1:0]  opcode;
    logic [IDX_W-1:0] ext;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rm;
    logic             undef;
  } dec_t;
endpackage

// File: rtl/fpdec_front.sv
module fpdec_front
  import fpdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output cls_e               cls_o,
  output logic               dbl_o,
  output logic               cp_bad_o,
  output logic               major_bad_o
);
  logic [3:0] cp;
  logic [3:0] major;

  assign cp       = instr_i[11:8];
  assign major    = instr_i[27:24];
  assign dbl_o    = (cp == CP_DBL);
  assign cp_bad_o = (cp != CP_SGL) && (cp != CP_DBL);

  always_comb begin
    cls_o       = CLS_RT;
    major_bad_o = 1'b0;
    unique case (major)
      4'hE:       cls_o = instr_i[4] ? CLS_RT : CLS_DP;
      4'hC, 4'hD: cls_o = (dbl_o && instr_i[22]) ? CLS_TWO : CLS_LS;
      default:    major_bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fpdec_dp.sv
module fpdec_dp
  import fpdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               dbl_i,
  output logic [OP_W-1:0]    opcode_o,
  output idx_t               idx_o
);
  logic [IDX_W-1:0] sub;
  logic             is_ext;
  logic             op_ok;
  logic             sub_ok;
  logic             narrow_dst;
  logic             narrow_src;
  logic             widen;
  logic [IDX_W-1:0] f_d_sgl, f_d_dbl, f_n_sgl, f_n_dbl, f_m_sgl, f_m_dbl;

  assign opcode_o = {instr_i[23], instr_i[21], instr_i[20], instr_i[6]};
  assign sub      = {instr_i[19:16], instr_i[7]};
  assign is_ext   = (opcode_o == OP_EXT);
  assign op_ok    = (opcode_o <= 4'd8) || is_ext;

  always_comb begin
    unique case (sub)
      5'd0, 5'd1, 5'd2, 5'd3,
      5'd8, 5'd9, 5'd10, 5'd11,
      5'd15, 5'd16, 5'd17,
      5'd24, 5'd25, 5'd26, 5'd27: sub_ok = 1'b1;
      default:                    sub_ok = 1'b0;
    endcase
  end

  assign narrow_dst = is_ext && ((sub == 5'd15) || (sub > 5'd17));
  assign narrow_src = is_ext && ((sub == 5'd16) || (sub == 5'd17));
  assign widen      = is_ext && (sub == 5'd15);

  assign f_d_sgl = {instr_i[15:12], instr_i[22]};
  assign f_d_dbl = {1'b0, instr_i[15:12]};
  assign f_n_sgl = {instr_i[19:16], instr_i[7]};
  assign f_n_dbl = {1'b0, instr_i[19:16]};
  assign f_m_sgl = {instr_i[3:0], instr_i[5]};
  assign f_m_dbl = {1'b0, instr_i[3:0]};

  always_comb begin
    idx_o       = '0;
    idx_o.undef = !op_ok || (is_ext && !sub_ok);
    if (dbl_i) begin
      if (is_ext) begin
        idx_o.rn = sub;
      end else begin
        idx_o.rn = f_n_dbl;
        if (instr_i[7]) idx_o.undef = 1'b1;
      end
      if (narrow_dst) begin
        idx_o.rd = f_d_sgl;
      end else begin
        idx_o.rd = f_d_dbl;
        if (instr_i[22]) idx_o.undef = 1'b1;
      end
      if (narrow_src) begin
        idx_o.rm = f_m_sgl;
      end else begin
        idx_o.rm = f_m_dbl;
        if (instr_i[5]) idx_o.undef = 1'b1;
      end
    end else begin
      idx_o.rn = f_n_sgl;
      idx_o.rm = f_m_sgl;
      if (widen) begin
        idx_o.rd = f_d_dbl;
        if (instr_i[22]) idx_o.undef = 1'b1;
      end else begin
        idx_o.rd = f_d_sgl;
      end
    end
  end
endmodule

// File: rtl/fpdec_xfer.sv
module fpdec_xfer
  import fpdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               dbl_i,
  input  cls_e               cls_i,
  output idx_t               idx_o
);
  localparam logic [6:0] RT_RSVD = 7'h6F;

  always_comb begin
    idx_o = '0;
    unique case (cls_i)
      CLS_RT: begin
        idx_o.rd    = {1'b0, instr_i[15:12]};
        idx_o.undef = |(instr_i[6:0] & RT_RSVD);
        if (dbl_i) begin
          idx_o.rn = {1'b0, instr_i[19:16]};
          if (instr_i[7]) idx_o.undef = 1'b1;
        end else begin
          idx_o.rn = {instr_i[19:16], instr_i[7]};
        end
      end
      CLS_TWO: begin
        idx_o.rn    = {1'b0, instr_i[19:16]};
        idx_o.rd    = {1'b0, instr_i[15:12]};
        idx_o.rm    = {1'b0, instr_i[3:0]};
        idx_o.undef = instr_i[5];
      end
      CLS_LS: begin
        idx_o.rn = {1'b0, instr_i[19:16]};
        idx_o.rd = dbl_i ? {1'b0, instr_i[15:12]} : {instr_i[15:12], instr_i[22]};
      end
      default: idx_o = '0;
    endcase
  end
endmodule

// File: rtl/fp_cop_decoder.sv
module fp_cop_decoder
  import fpdec_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  output logic                 valid_o,
  output logic [1:0]           class_o,
  output logic                 dbl_o,
  output logic [OP_W-1:0]      opcode_o,
  output logic [IDX_W-1:0]     ext_o,
  output logic [IDX_W-1:0]     rd_o,
  output logic [IDX_W-1:0]     rn_o,
  output logic [IDX_W-1:0]     rm_o,
  output logic                 undef_o
);
  cls_e            cls;
  logic            dbl, cp_bad, major_bad;
  logic [OP_W-1:0] dp_op;
  idx_t            dp_idx, xf_idx, sel_idx;
  dec_t            dec_d, dec_q;
  logic            vld_q;

  fpdec_front i_front (
    .instr_i    (instr_i),
    .cls_o      (cls),
    .dbl_o      (dbl),
    .cp_bad_o   (cp_bad),
    .major_bad_o(major_bad)
  );

  fpdec_dp i_dp (
    .instr_i (instr_i),
    .dbl_i   (dbl),
    .opcode_o(dp_op),
    .idx_o   (dp_idx)
  );

  fpdec_xfer i_xfer (
    .instr_i(instr_i),
    .dbl_i  (dbl),
    .cls_i  (cls),
    .idx_o  (xf_idx)
  );

  always_comb begin
    sel_idx = (cls == CLS_DP) ? dp_idx : xf_idx;
    if (major_bad) sel_idx = '0;
    dec_d.cls    = cls;
    dec_d.dbl    = dbl;
    dec_d.opcode = (cls == CLS_DP && !major_bad) ? dp_op : '0;
    dec_d.ext    = {instr_i[19:16], instr_i[7]};
    dec_d.rd     = sel_idx.rd;
    dec_d.rn     = sel_idx.rn;
    dec_d.rm     = sel_idx.rm;
    dec_d.undef  = sel_idx.undef | cp_bad | major_bad;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) dec_q <= dec_d;
    end
  end

  assign valid_o  = vld_q;
  assign class_o  = dec_q.cls;
  assign dbl_o    = dec_q.dbl;
  assign opcode_o = dec_q.opcode;
  assign ext_o    = dec_q.ext;
  assign rd_o     = dec_q.rd;
  assign rn_o     = dec_q.rn;
  assign rm_o     = dec_q.rm;
  assign undef_o  = dec_q.undef;
endmodule

// File: rtl/fpdec_checker.sv
module fpdec_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] instr_i,
  input logic        valid_o,
  input logic [1:0]  class_o,
  input logic        dbl_o,
  input logic [3:0]  opcode_o,
  input logic [4:0]  rd_o,
  input logic        undef_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_valid_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (valid_o == $past(valid_i)));

  assert_hold_when_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(valid_i)) |-> ($stable(rd_o) && $stable(class_o) && $stable(undef_o)));

  assert_bad_cp_undef_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && ($past(instr_i[11:8]) != 4'hA) && ($past(instr_i[11:8]) != 4'hB))
      |-> undef_o);

  assert_rt_reserved_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && (class_o == 2'd0) && (($past(instr_i[6:0]) & 7'h6F) != 7'h0))
      |-> undef_o);

  assert_two_reg_needs_dbl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 2'd3) |-> dbl_o);

  assert_opcode_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && class_o == 2'd1 && !undef_o) |-> (opcode_o <= 4'd8 || opcode_o == 4'd15));
endmodule

bind fp_cop_decoder fpdec_checker i_fpdec_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .instr_i (instr_i),
  .valid_o (valid_o),
  .class_o (class_o),
  .dbl_o   (dbl_o),
  .opcode_o(opcode_o),
  .rd_o    (rd_o),
  .undef_o (undef_o)
);

// File: tb/test_fp_cop_decoder.sv
`timescale 1ns/1ps
module test_fp_cop_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        valid_o;
  logic [1:0]  class_o;
  logic        dbl_o;
  logic [3:0]  opcode_o;
  logic [4:0]  ext_o, rd_o, rn_o, rm_o;
  logic        undef_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  typedef struct packed {
    logic [1:0] cls;
    logic       dbl;
    logic [3:0] op;
    logic [4:0] ext;
    logic [4:0] rd;
    logic [4:0] rn;
    logic [4:0] rm;
    logic       u;
  } exp_t;

  always #2 clk_i = ~clk_i;

  fp_cop_decoder i_fp_cop_decoder (
    .clk_i, .rst_ni, .valid_i, .instr_i, .valid_o, .class_o, .dbl_o,
    .opcode_o, .ext_o, .rd_o, .rn_o, .rm_o, .undef_o
  );

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic bit sub_legal(logic [4:0] s);
    return (s < 5'd4) || (s >= 5'd8 && s < 5'd12) || (s >= 5'd15 && s < 5'd18) ||
           (s >= 5'd24 && s < 5'd28);
  endfunction

  function automatic exp_t model(logic [31:0] w);
    exp_t e;
    logic [3:0] op;
    logic [4:0] s;
    e = '0;
    e.dbl = (w[11:8] == 4'd11);
    s = {w[19:16], w[7]};
    e.ext = s;
    if (w[27:24] == 4'hE && w[4]) begin         // register transfer
      e.cls = 2'd0;
      e.rd = {1'b0, w[15:12]};
      e.u = (w[0] | w[1] | w[2] | w[3] | w[5] | w[6]);
      if (e.dbl) begin e.rn = {1'b0, w[19:16]}; e.u |= w[7]; end
      else e.rn = s;
    end else if (w[27:24] == 4'hE) begin        // data processing
      e.cls = 2'd1;
      op = {w[23], w[21], w[20], w[6]};
      e.op = op;
      e.u = !(op < 4'd9 || op == 4'd15) || (op == 4'd15 && !sub_legal(s));
      if (!e.dbl) begin
        e.rn = s;
        e.rm = {w[3:0], w[5]};
        if (op == 4'd15 && s == 5'd15) begin e.rd = {1'b0, w[15:12]}; e.u |= w[22]; end
        else e.rd = {w[15:12], w[22]};
      end else begin
        if (op == 4'd15) e.rn = s;
        else begin e.rn = {1'b0, w[19:16]}; e.u |= w[7]; end
        // R8 mixed-width operands
        if (op == 4'd15 && (s == 5'd15 || s >= 5'd18)) e.rd = {w[15:12], w[22]};
        else begin e.rd = {1'b0, w[15:12]}; e.u |= w[22]; end
        if (op == 4'd15 && (s == 5'd16 || s == 5'd17)) e.rm = {w[3:0], w[5]};
        else begin e.rm = {1'b0, w[3:0]}; e.u |= w[5]; end
      end
    end else if (w[27:24] == 4'hC || w[27:24] == 4'hD) begin
      e.rn = {1'b0, w[19:16]};
      if (e.dbl && w[22]) begin
        e.cls = 2'd3; e.rd = {1'b0, w[15:12]}; e.rm = {1'b0, w[3:0]}; e.u = w[5];
      end else begin
        e.cls = 2'd2; e.rd = e.dbl ? {1'b0, w[15:12]} : {w[15:12], w[22]};
      end
    end else begin
      e.cls = 2'd0; e.u = 1'b1;
    end
    if (w[11:8] != 4'd10 && w[11:8] != 4'd11) e.u = 1'b1;
    return e;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at following negedge
  task automatic apply(logic [31:0] w, string rq_u, string rq_f);
    exp_t e;
    e = model(w);
    instr_i = w;
    valid_i = 1'b1;
    @(negedge clk_i);
    chk("R10", "valid_o", valid_o, 1);
    chk("R2", "class", class_o, e.cls);
    chk("R1", "dbl", dbl_o, e.dbl);
    chk(rq_u, "undef", undef_o, e.u);
    chk("R4", "opcode", opcode_o, e.op);
    chk("R5", "ext", ext_o, e.ext);
    chk(rq_f, "rd", rd_o, e.rd);
    chk(rq_f, "rn", rn_o, e.rn);
    chk(rq_f, "rm", rm_o, e.rm);
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [11:0] k;
    logic [4:0]  se;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11", "valid_o", valid_o, 0);
    chk("R11", "class", class_o, 0);
    chk("R11", "undef", undef_o, 0);
    chk("R11", "rd|rn|rm", {rd_o, rn_o, rm_o}, 0);
    chk("R11", "opcode|ext", {opcode_o, ext_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 / R2: every major nibble against every coprocessor number
    for (int mj = 0; mj < 16; mj++)
      for (int cp = 0; cp < 16; cp++)
        for (int r = 0; r < 3; r++) begin
          w = rnd();
          w[27:24] = mj[3:0];
          w[11:8]  = cp[3:0];
          apply(w, "R1", "R2");
        end

    // R3: all low byte patterns of a register transfer
    for (int lo = 0; lo < 256; lo++)
      for (int dp = 0; dp < 2; dp++)
        for (int dir = 0; dir < 4; dir++) begin
          w = rnd();
          w[27:24] = 4'hE; w[4] = 1'b1;
          w[7:0] = lo[7:0]; w[4] = 1'b1;
          w[21:20] = dir[1:0];
          w[11:8] = dp[0] ? 4'hB : 4'hA;
          apply(w, "R3", "R3");
        end

    // R4-R8: opcode, sub-opcode, guard bits and precision, full cross
    for (int c = 0; c < 4096; c++) begin
      k = c[11:0];
      w = rnd();
      w[27:24] = 4'hE; w[4] = 1'b0;
      {w[23], w[21], w[20], w[6]} = k[3:0];
      w[19:16] = k[7:4];
      w[7]  = k[8];
      w[22] = k[9];
      w[5]  = k[10];
      w[11:8] = k[11] ? 4'hB : 4'hA;
      se = {w[19:16], w[7]};
      apply(w, (k[3:0] == 4'd15) ? "R5" : "R4", k[11] ? "R7" : "R6");
    end

    // R9: load/store versus two-register transfer
    for (int mj = 0; mj < 2; mj++)
      for (int dp = 0; dp < 2; dp++)
        for (int b = 0; b < 4; b++)
          for (int r = 0; r < 16; r++) begin
            w = rnd();
            w[27:24] = mj[0] ? 4'hD : 4'hC;
            w[11:8] = dp[0] ? 4'hB : 4'hA;
            w[22] = b[0]; w[5] = b[1];
            apply(w, "R9", "R9");
          end

    // R10: idle cycles leave outputs untouched, valid_o drops one cycle later
    w = 32'h0EB0_0A40;
    apply(w, "R10", "R10");
    valid_i = 1'b0;
    for (int r = 0; r < 4; r++) begin
      instr_i = rnd();
      @(negedge clk_i);
      chk("R10", "valid_o idle", valid_o, 0);
      chk("R10", "rd hold", rd_o, model(w).rd);
      chk("R10", "class hold", class_o, model(w).cls);
      chk("R10", "undef hold", undef_o, model(w).u);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule